// File: doc/BRIEF.md
# Packed Colour Lookup Table

This block is a 256-entry colour lookup table that a processor fills through a window of 128 32-bit registers. Every bus word holds two 16-bit colour entries. Each entry carries three 5-bit components. The block keeps the raw words so that software can read them back. It also keeps an expanded 24-bit RGB copy of every entry, so the pixel path never has to do the conversion.

A pixel pipeline presents an 8-bit index on every clock and receives the matching 24-bit colour one cycle later. The bus port and the lookup port work independently, and neither ever stalls the other. Bus accesses whose byte offset falls outside the palette window have no effect on the table, and reads of such offsets return zero.

Top module: `packed_clut`

## Requirements
- R1: After reset, `pix_rgb_o` and `bus_rdata_o` are zero, and every raw word and every expanded entry reads as zero.
- R2: A bus write with byte offset in [0x200, 0x3FF] stores the full 32-bit data in word n = (offset − 0x200) >> 2, and the low two offset bits are ignored. A bus read of the same window returns that raw word on `bus_rdata_o` one cycle after the request. `bus_rdata_o` holds its value in cycles without a read request.
- R3: Bits [15:0] of word n define entry 2n, and bits [31:16] of word n define entry 2n+1.
- R4: Within each 16-bit half, red sits in bits [4:0], green in bits [9:5] and blue in bits [14:10]. Bit 15 has no effect on the colour, but it is kept in the raw word.
- R5: Each 5-bit component becomes 8 bits by a left shift of three, with the three low bits zero. `pix_rgb_o` is {red[23:16], green[15:8], blue[7:0]}.
- R6: `pix_rgb_o` shows the colour of the entry selected by `pix_idx_i` at the previous clock edge, which is a latency of one cycle.
- R7: When a write and a lookup of the same entry meet at one edge, the lookup returns the value the entry had before the write.
- R8: Writes whose byte offset lies outside [0x200, 0x3FF] change nothing, and reads of such offsets return zero.
- R9: Bus reads and writes in the same cycle as a lookup do not disturb the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pix_idx_i | input | IDX_W (8) | Lookup index |
| pix_rgb_o | output | 24 | Registered lookup colour |

## Verification
The checker assumes that a bus strobe carries a defined write flag and address, and that the lookup index is a defined value on every clock. With these inputs the write-tracking and hold properties refer to real accesses only. The stimulus drives every input on the falling edge to a known value in every cycle, including idle bus cycles. It also draws offsets on both sides of the window, so that the boundary behaviour is covered without unknowns reaching the decode.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int COMP_W = 5;
  localparam int OUT_W  = 8;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef struct packed {
    logic [OUT_W-1:0] r;
    logic [OUT_W-1:0] g;
    logic [OUT_W-1:0] b;
  } rgb_t;

  localparam int RGB_W = $bits(rgb_t);

  // bit 15 (intensity) deliberately not an argument
  function automatic rgb_t expand555(logic [3*COMP_W-1:0] h);
    rgb_t c;
    c.r = {h[COMP_W-1:0],          {(OUT_W-COMP_W){1'b0}}};
    c.g = {h[2*COMP_W-1:COMP_W],   {(OUT_W-COMP_W){1'b0}}};
    c.b = {h[3*COMP_W-1:2*COMP_W], {(OUT_W-COMP_W){1'b0}}};
    return c;
  endfunction
endpackage

// File: rtl/clut_addr_dec.sv
module clut_addr_dec #(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int NWORDS = 128,
  localparam int WIDX_W = $clog2(NWORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [WIDX_W-1:0] widx_o
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + 4*NWORDS);

  logic [ADDR_W-1:0] offs;
  logic              unused_offs;

  assign hit_o       = ({1'b0, addr_i} >= LO) && ({1'b0, addr_i} < HI);
  assign offs        = addr_i - LO[ADDR_W-1:0];
  assign widx_o      = offs[WIDX_W+1:2];
  assign unused_offs = ^{offs[ADDR_W-1:WIDX_W+2], offs[1:0]};
endmodule

// File: rtl/clut_raw_store.sv
module clut_raw_store #(
  parameter int NWORDS = 128,
  parameter int DW     = 32,
  localparam int WIDX_W = $clog2(NWORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic                 rd_hit_i,
  input  logic [WIDX_W-1:0]    widx_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NWORDS*DW-1:0] mem_flat_o
);
  logic [DW-1:0] mem_q [NWORDS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NWORDS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_hit_i ? mem_q[widx_i] : '0;
  end

  assign rdata_o = rdata_q;

  for (genvar w = 0; w < NWORDS; w++) begin : g_flat
    assign mem_flat_o[w*DW +: DW] = mem_q[w];
  end
endmodule

// File: rtl/clut_color_store.sv
module clut_color_store
  import clut_pkg::*;
#(
  parameter int NWORDS = 128,
  localparam int NENT   = 2 * NWORDS,
  localparam int IDX_W  = $clog2(NENT),
  localparam int WIDX_W = $clog2(NWORDS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [WIDX_W-1:0]      widx_i,
  input  logic [WORD_W-1:0]      wdata_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [RGB_W-1:0]       rgb_o,
  output logic [NENT*RGB_W-1:0]  ent_flat_o
);
  rgb_t ent [NENT];
  rgb_t rgb_q;
  logic unused_ibits;

  assign unused_ibits = wdata_i[HALF_W-1] ^ wdata_i[WORD_W-1];

  for (genvar w = 0; w < NWORDS; w++) begin : g_pair
    rgb_t lo_q, hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en_i && (widx_i == WIDX_W'(w))) begin
        lo_q <= expand555(wdata_i[3*COMP_W-1:0]);
        hi_q <= expand555(wdata_i[HALF_W +: 3*COMP_W]);
      end
    end
    assign ent[2*w]   = lo_q;
    assign ent[2*w+1] = hi_q;
    assign ent_flat_o[(2*w)*RGB_W   +: RGB_W] = lo_q;
    assign ent_flat_o[(2*w+1)*RGB_W +: RGB_W] = hi_q;
  end

  // registered read of pre-edge contents: collision returns old value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_q <= '0;
    else         rgb_q <= ent[idx_i];
  end

  assign rgb_o = rgb_q;
endmodule

// File: rtl/packed_clut.sv
module packed_clut
  import clut_pkg::*;
#(
  parameter int NWORDS = 128,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  localparam int NENT   = 2 * NWORDS,
  localparam int IDX_W  = $clog2(NENT),
  localparam int WIDX_W = $clog2(NWORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [IDX_W-1:0]  pix_idx_i,
  output logic [23:0]       pix_rgb_o
);
  logic                     acc_hit;
  logic [WIDX_W-1:0]        wr_widx;
  logic                     wr_hit;
  logic                     rd_en;
  logic [NWORDS*WORD_W-1:0] raw_flat;
  logic [NENT*RGB_W-1:0]    ent_flat;

  clut_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .NWORDS(NWORDS)) u_dec (
    .addr_i (bus_addr_i),
    .hit_o  (acc_hit),
    .widx_o (wr_widx)
  );

  assign wr_hit = bus_req_i & bus_we_i & acc_hit;
  assign rd_en  = bus_req_i & ~bus_we_i;

  clut_raw_store #(.NWORDS(NWORDS), .DW(WORD_W)) u_raw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_hit),
    .rd_en_i    (rd_en),
    .rd_hit_i   (acc_hit),
    .widx_i     (wr_widx),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .mem_flat_o (raw_flat)
  );

  clut_color_store #(.NWORDS(NWORDS)) u_col (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_hit),
    .widx_i     (wr_widx),
    .wdata_i    (bus_wdata_i),
    .idx_i      (pix_idx_i),
    .rgb_o      (pix_rgb_o),
    .ent_flat_o (ent_flat)
  );
endmodule

// File: rtl/clut_chk.sv
module clut_chk #(
  parameter int NWORDS = 128,
  parameter int ADDR_W = 12,
  localparam int NENT   = 2 * NWORDS,
  localparam int IDX_W  = $clog2(NENT),
  localparam int WIDX_W = $clog2(NWORDS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_req_i,
  input logic                  bus_we_i,
  input logic [31:0]           bus_wdata_i,
  input logic [31:0]           bus_rdata_o,
  input logic [IDX_W-1:0]      pix_idx_i,
  input logic [23:0]           pix_rgb_o,
  input logic                  acc_hit,
  input logic                  wr_hit,
  input logic [WIDX_W-1:0]     wr_widx,
  input logic [NWORDS*32-1:0]  raw_flat,
  input logic [NENT*24-1:0]    ent_flat
);
  AST_RESET_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pix_rgb_o == '0 && bus_rdata_o == '0)); // R1

  AST_RAW_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> raw_flat[int'($past(wr_widx))*32 +: 32] == $past(bus_wdata_i)); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> $stable(bus_rdata_o)); // R2

  AST_PAIR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> ent_flat[int'($past(wr_widx))*48 +: 24] ==
      {$past(bus_wdata_i[4:0]), 3'b000, $past(bus_wdata_i[9:5]), 3'b000,
       $past(bus_wdata_i[14:10]), 3'b000}); // R3

  AST_PAIR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> ent_flat[int'($past(wr_widx))*48 + 24 +: 24] ==
      {$past(bus_wdata_i[20:16]), 3'b000, $past(bus_wdata_i[25:21]), 3'b000,
       $past(bus_wdata_i[30:26]), 3'b000}); // R3

  AST_RGB_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_rgb_o[2:0] == 3'b0 && pix_rgb_o[10:8] == 3'b0 && pix_rgb_o[18:16] == 3'b0)); // R5

  AST_LUT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_hit) && $stable(pix_idx_i)) |=> $stable(pix_rgb_o)); // R6

  AST_COLLIDE_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && pix_idx_i[IDX_W-1:1] == wr_widx) |=>
      pix_rgb_o == $past(ent_flat[int'(pix_idx_i)*24 +: 24])); // R7

  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && !acc_hit) |=> bus_rdata_o == '0); // R8

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && !acc_hit) |=> ($stable(raw_flat) && $stable(ent_flat))); // R8
endmodule

bind packed_clut clut_chk #(.NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pix_idx_i   (pix_idx_i),
  .pix_rgb_o   (pix_rgb_o),
  .acc_hit     (acc_hit),
  .wr_hit      (wr_hit),
  .wr_widx     (wr_widx),
  .raw_flat    (raw_flat),
  .ent_flat    (ent_flat)
);

// File: tb/packed_clut_tb_top.sv
`timescale 1ns/1ps
module packed_clut_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  idx = '0;
  logic [23:0] rgb;

  int unsigned model [128];
  logic [31:0] exp_rdata = '0;
  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  int unsigned lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  packed_clut dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .bus_req_i (req), .bus_we_i (we), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .pix_idx_i (idx), .pix_rgb_o (rgb)
  );

  function automatic logic [23:0] ref_rgb(int e);
    logic [31:0] w;
    logic [15:0] h;
    w = model[e/2];
    h = (e % 2) ? w[31:16] : w[15:0];
    return {h[4:0], 3'b0, h[9:5], 3'b0, h[14:10], 3'b0};
  endfunction

  function automatic bit in_win(logic [11:0] a);
    return (a >= 12'h200) && (a < 12'h400);
  endfunction

  task automatic compare(string tag, string what, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // one clock: drive at negedge, check after the following posedge
  task automatic cyc(bit r, bit w, logic [11:0] a, logic [31:0] d, logic [7:0] ix, string tag);
    logic [23:0] exp_rgb;
    req = r; we = w; addr = a; wdata = d; idx = ix;
    exp_rgb = ref_rgb(int'(ix));
    if (r && !w) exp_rdata = in_win(a) ? model[(a - 12'h200) >> 2] : 32'h0;
    if (r && w && in_win(a)) model[(a - 12'h200) >> 2] = d;
    @(posedge clk); #1;
    compare(tag, "rgb", {8'h0, rgb}, {8'h0, exp_rgb});
    compare(tag, "rdata", rdata, exp_rdata);
    @(negedge clk);
  endtask

  function automatic int unsigned step_lfsr();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hA300_0001 : 32'h0);
    return lfsr;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    #1; compare("R1", "rgb_reset", {8'h0, rgb}, 32'h0);
    compare("R1", "rdata_reset", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: contents zero
    cyc(1, 0, 12'h200, 0, 8'd0,   "R1");
    cyc(1, 0, 12'h3FC, 0, 8'd255, "R1");
    cyc(0, 0, 12'h000, 0, 8'd77,  "R1");
    // R2: write and read back raw words, low offset bits ignored
    cyc(1, 1, 12'h204, 32'hDEAD_BEEF, 8'd0, "R2");
    cyc(1, 0, 12'h207, 0, 8'd2, "R2");
    cyc(0, 0, 12'h000, 0, 8'd3, "R2");   // hold
    cyc(1, 1, 12'h3FC, 32'h8001_7FFF, 8'd0, "R2");
    cyc(1, 0, 12'h3FC, 0, 8'd254, "R2");
    // R3/R4/R5: halves, fields, intensity bit, expansion
    cyc(1, 1, 12'h208, 32'h801F_03E0, 8'd4, "R3");
    cyc(0, 0, 12'h000, 0, 8'd4, "R3");
    cyc(0, 0, 12'h000, 0, 8'd5, "R4");
    cyc(1, 1, 12'h20C, 32'h7C00_FC00, 8'd6, "R4");
    cyc(0, 0, 12'h000, 0, 8'd6, "R4");
    cyc(0, 0, 12'h000, 0, 8'd7, "R5");
    cyc(0, 0, 12'h000, 0, 8'd255, "R5");
    // R6: latency over changing index
    for (int i = 0; i < 8; i++) cyc(0, 0, 12'h000, 0, 8'(i), "R6");
    // R7: collision returns old value, then new
    cyc(1, 1, 12'h210, 32'h1234_5678, 8'd8, "R7");
    cyc(1, 1, 12'h210, 32'h0ABC_7DEF, 8'd9, "R7");
    cyc(0, 0, 12'h000, 0, 8'd9, "R7");
    // R8: outside window
    cyc(1, 1, 12'h1FC, 32'hFFFF_FFFF, 8'd0, "R8");
    cyc(1, 1, 12'h400, 32'hFFFF_FFFF, 8'd254, "R8");
    cyc(1, 0, 12'h1FC, 0, 8'd255, "R8");
    cyc(1, 0, 12'h200, 0, 8'd1, "R8");
    cyc(1, 0, 12'h400, 0, 8'd0, "R8");
    cyc(1, 0, 12'h3FC, 0, 8'd0, "R8");
    // R9: mixed traffic alongside lookups
    for (int i = 0; i < 600; i++) begin
      int unsigned a, b, c;
      logic [11:0] ad;
      a = step_lfsr(); b = step_lfsr(); c = step_lfsr();
      ad = (a[3:0] == 0) ? 12'(a >> 8) : (12'h200 + 12'({a[14:8], a[17:16]}));
      cyc(a[4] | a[5], a[6], ad, b, 8'(c), "R9");
    end
    finish_run();
  end
endmodule